// File: doc/BRIEF.md
# Guarded Nonvolatile Byte-Write Controller

This block sits between a host register bus and a small byte-wide nonvolatile data array, modelled here as a register array. The host loads an address register and a data register, then commits a byte through a control register. A commit is honoured only if the host has written the two unlock bytes 55h and AAh to a key register right before it. Every accepted write first erases the target byte and then programs the new value.

Once a commit is accepted, the controller waits for a number of falling edges on an external serial clock before it starts programming. It then stays busy for a programming interval and a discharge interval, both given in system clock cycles. During this time it refuses all host traffic. Completion and misuse are reported through two sticky flags in the control register. A read strobe copies the addressed byte into the data register when the controller is idle.

Top module: `nvbyte_guard`

## Requirements
- R1: After synchronous reset the address, data and control registers read 0, `busy` is 0, and every array location reads FFh.
- R2: The bus select codes are 0 = address, 1 = data, 2 = control and 3 = key. `rd_stb` while idle loads the data register with the addressed byte at the next clock edge. The control byte layout is bit 7 program-memory select, bit 6 configuration select, bit 4 done, bit 3 error, bit 2 write enable and bit 1 start. Bits 5 and 0 read 0.
- R3: A commit needs key writes of 55h and then AAh as the last two accepted bus writes before the control write that sets bit 1. Any other bus write in between cancels the unlock, and so does the reversed order. Every control write clears the unlock state.
- R4: A commit is accepted only if write enable was already 1 before the commit write and the written bits 7 and 6 are both 0. After an accepted commit, `busy` is 1 and control bit 1 reads 1.
- R5: A rejected commit sets the error bit. It leaves bit 1 at 0 and `busy` at 0, and it leaves the array unchanged.
- R6: Programming waits for the 4th falling edge of `sclk` after the commit. `sclk` passes through a two-flop synchronizer. Call the first clock edge that samples that 4th low level edge 1. Then `busy` and bit 1 drop after edge 3+P11+P10.
- R7: An accepted write erases the location to FFh when programming starts and holds the new byte once the operation completes, whatever the previous contents were.
- R8: On completion, bit 1 clears and the done bit sets. The done and error bits are set only by hardware. A control write with bit 4 (or bit 3) at 0 clears it, and writing 1 leaves it unchanged.
- R9: While busy, every bus write is ignored and sets the error bit, and `rd_stb` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Host register write strobe |
| bus_sel | input | 2 | Register select |
| bus_wdata | input | DW | Host write data |
| rd_stb | input | 1 | Array read strobe |
| sclk | input | 1 | External serial clock, asynchronous |
| addr_q | output | AW | Address register |
| data_q | output | DW | Data register |
| ctrl_q | output | 8 | Control register readback |
| busy | output | 1 | Write operation in progress |
| done_flag | output | 1 | Sticky completion flag |
| err_flag | output | 1 | Sticky error flag |

## Verification
A host bus write and the end of the discharge interval can fall on the same clock edge. The write is then judged against the busy state that held before that edge. The bench provokes this by counting clock edges from the fourth serial-clock fall and issuing a data register write that is sampled on exactly the completion edge. It expects the write to be dropped, the error bit and the done bit to be set together, and the stored byte to match the committed value.

// File: rtl/nvg_pkg.sv
package nvg_pkg;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_DATA = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_KEY  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        UL_IDLE,
        UL_HALF,
        UL_OPEN
    } unlock_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_WAIT,
        PH_PROG,
        PH_DISCH
    } phase_e;

    localparam int unsigned BIT_PSEL = 7;
    localparam int unsigned BIT_CSEL = 6;
    localparam int unsigned BIT_DONE = 4;
    localparam int unsigned BIT_ERR  = 3;
    localparam int unsigned BIT_WREN = 2;
    localparam int unsigned BIT_WR   = 1;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    typedef struct packed {
        logic psel;
        logic csel;
        logic done;
        logic err;
        logic wren;
        logic wr;
    } ctrl_t;

    function automatic logic [7:0] pack_ctrl(input ctrl_t c);
        logic [7:0] b;
        b           = 8'h00;
        b[BIT_PSEL] = c.psel;
        b[BIT_CSEL] = c.csel;
        b[BIT_DONE] = c.done;
        b[BIT_ERR]  = c.err;
        b[BIT_WREN] = c.wren;
        b[BIT_WR]   = c.wr;
        return b;
    endfunction

endpackage

// File: rtl/nvg_unlock.sv
module nvg_unlock
    import nvg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       evt,
    input  reg_sel_e   sel,
    input  logic [7:0] wdata,
    output logic       open
);
    unlock_e st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= UL_IDLE;
        end else if (evt) begin
            if (sel == SEL_KEY) begin
                if (wdata == KEY_FIRST)
                    st <= UL_HALF;
                else if (wdata == KEY_SECOND && st == UL_HALF)
                    st <= UL_OPEN;
                else
                    st <= UL_IDLE;
            end else begin
                st <= UL_IDLE;
            end
        end
    end

    assign open = (st == UL_OPEN);
endmodule

// File: rtl/nvg_sclk_edges.sv
module nvg_sclk_edges #(
    parameter int unsigned EDGES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic arm,
    output logic hit
);
    localparam int unsigned CW = $clog2(EDGES + 1);

    logic [2:0]    sync_q;
    logic [CW-1:0] cnt;
    logic          fall;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 3'b000;
        else     sync_q <= {sync_q[1:0], sclk};
    end

    assign fall = sync_q[2] & ~sync_q[1];
    assign hit  = arm & fall & (cnt == CW'(EDGES - 1));

    always_ff @(posedge clk) begin
        if (rst || !arm)  cnt <= '0;
        else if (hit)     cnt <= '0;
        else if (fall)    cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/nvg_store.sv
module nvg_store #(
    parameter int unsigned AW   = 8,
    parameter int unsigned DW   = 8,
    parameter logic [DW-1:0] FILL = '1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= FILL;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/nvbyte_guard.sv
module nvbyte_guard
    import nvg_pkg::*;
#(
    parameter int unsigned AW    = 8,
    parameter int unsigned DW    = 8,
    parameter int unsigned P11   = 6,
    parameter int unsigned P10   = 3,
    parameter int unsigned EDGES = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_we,
    input  logic [1:0]    bus_sel,
    input  logic [DW-1:0] bus_wdata,
    input  logic          rd_stb,
    input  logic          sclk,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] data_q,
    output logic [7:0]    ctrl_q,
    output logic          busy,
    output logic          done_flag,
    output logic          err_flag
);
    localparam int unsigned PMAX = (P11 > P10) ? P11 : P10;
    localparam int unsigned TW   = $clog2(PMAX + 1);
    localparam logic [DW-1:0] ERASED = '1;

    phase_e        phase;
    ctrl_t         ctrl;
    logic [TW-1:0] tmr;
    reg_sel_e      sel;
    logic          wr_acc;
    logic          unlock_ok;
    logic          start_try;
    logic          start_ok;
    logic          edge_hit;
    logic          arr_we;
    logic [DW-1:0] arr_wdata;
    logic [DW-1:0] arr_rdata;

    assign sel       = reg_sel_e'(bus_sel);
    assign busy      = (phase != PH_IDLE);
    assign wr_acc    = bus_we && !busy;
    assign start_try = wr_acc && (sel == SEL_CTRL) && bus_wdata[BIT_WR];
    assign start_ok  = start_try && unlock_ok && ctrl.wren
                       && !bus_wdata[BIT_PSEL] && !bus_wdata[BIT_CSEL];

    nvg_unlock u_unlock (
        .clk   (clk),
        .rst   (rst),
        .evt   (wr_acc),
        .sel   (sel),
        .wdata (bus_wdata[7:0]),
        .open  (unlock_ok)
    );

    nvg_sclk_edges #(.EDGES(EDGES)) u_edges (
        .clk  (clk),
        .rst  (rst),
        .sclk (sclk),
        .arm  (phase == PH_WAIT),
        .hit  (edge_hit)
    );

    // erase on the first programming cycle, program on the last
    assign arr_we    = (phase == PH_PROG) && ((tmr == TW'(P11 - 1)) || (tmr == '0));
    assign arr_wdata = (tmr == '0) ? data_q : ERASED;

    nvg_store #(.AW(AW), .DW(DW), .FILL(ERASED)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (arr_we),
        .waddr (addr_q),
        .wdata (arr_wdata),
        .raddr (addr_q),
        .rdata (arr_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            tmr    <= '0;
            ctrl   <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (wr_acc) begin
                        case (sel)
                            SEL_ADDR: addr_q <= bus_wdata[AW-1:0];
                            SEL_DATA: data_q <= bus_wdata;
                            SEL_CTRL: begin
                                ctrl.psel <= bus_wdata[BIT_PSEL];
                                ctrl.csel <= bus_wdata[BIT_CSEL];
                                ctrl.wren <= bus_wdata[BIT_WREN];
                                ctrl.done <= ctrl.done & bus_wdata[BIT_DONE];
                                ctrl.err  <= (start_try && !start_ok) ? 1'b1
                                             : (ctrl.err & bus_wdata[BIT_ERR]);
                                ctrl.wr   <= start_ok;
                                if (start_ok) phase <= PH_WAIT;
                            end
                            default: ;
                        endcase
                    end else if (rd_stb) begin
                        data_q <= arr_rdata;
                    end
                end
                PH_WAIT: begin
                    if (edge_hit) begin
                        phase <= PH_PROG;
                        tmr   <= TW'(P11 - 1);
                    end
                end
                PH_PROG: begin
                    if (tmr == '0) begin
                        phase <= PH_DISCH;
                        tmr   <= TW'(P10 - 1);
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                PH_DISCH: begin
                    if (tmr == '0) begin
                        phase     <= PH_IDLE;
                        ctrl.wr   <= 1'b0;
                        ctrl.done <= 1'b1;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
            if (bus_we && busy) ctrl.err <= 1'b1;
        end
    end

    assign ctrl_q    = pack_ctrl(ctrl);
    assign done_flag = ctrl.done;
    assign err_flag  = ctrl.err;
endmodule

// File: rtl/nvg_guard_chk.sv
module nvg_guard_chk #(
    parameter int unsigned AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_we,
    input logic [1:0]    bus_sel,
    input logic [7:0]    bus_wdata,
    input logic          busy,
    input logic          err_flag,
    input logic          done_flag,
    input logic [AW-1:0] addr_q,
    input logic          arr_we,
    input logic          unlock_ok
);
    logic err_clear;
    assign err_clear = bus_we && !busy && (bus_sel == 2'd2) && !bus_wdata[3];

    AST_BUSY_WRITE_ERR: assert property (@(posedge clk) disable iff (rst)
        (busy && bus_we) |=> err_flag); // R9
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(addr_q)); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !err_clear) |=> err_flag); // R8
    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done_flag); // R8
    AST_START_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(unlock_ok)); // R3
    AST_ARRAY_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !arr_we); // R7
endmodule

bind nvbyte_guard nvg_guard_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_sel   (bus_sel),
    .bus_wdata (bus_wdata[7:0]),
    .busy      (busy),
    .err_flag  (err_flag),
    .done_flag (done_flag),
    .addr_q    (addr_q),
    .arr_we    (arr_we),
    .unlock_ok (unlock_ok)
);

// File: tb/nvbyte_guard_test.sv
module nvbyte_guard_test;
    localparam int CLK_PERIOD = 10;
    localparam int P11 = 6;
    localparam int P10 = 3;
    localparam int EXP_LAT = 3 + P11 + P10;
    localparam logic [1:0] S_ADDR = 2'd0, S_DATA = 2'd1, S_CTRL = 2'd2, S_KEY = 2'd3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_we = 1'b0;
    logic [1:0] bus_sel = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic       rd_stb = 1'b0;
    logic       sclk = 1'b0;
    logic [7:0] addr_q, data_q, ctrl_q;
    logic       busy, done_flag, err_flag;

    int errs = 0;
    int checks = 0;
    logic [7:0] mdl [256];

    always #(CLK_PERIOD / 2) clk = ~clk;

    nvbyte_guard #(.P11(P11), .P10(P10)) uut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .rd_stb(rd_stb), .sclk(sclk),
        .addr_q(addr_q), .data_q(data_q), .ctrl_q(ctrl_q),
        .busy(busy), .done_flag(done_flag), .err_flag(err_flag)
    );

    function automatic logic [7:0] ctrl_byte(input bit psel, input bit csel,
        input bit done, input bit err, input bit wren, input bit wr);
        return {psel, csel, 1'b0, done, err, wren, wr, 1'b0};
    endfunction

    // kind: 0 good, 1 no key, 2 reversed key, 3 configuration select set
    function automatic logic [7:0] exp_ctrl(input int kind);
        if (kind == 0) return ctrl_byte(0, 0, 1, 0, 1, 0);
        if (kind == 3) return ctrl_byte(0, 1, 0, 1, 1, 0);
        return ctrl_byte(0, 0, 0, 1, 1, 0);
    endfunction

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] v);
        bus_we = 1'b1; bus_sel = s; bus_wdata = v;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        wr(S_ADDR, a);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        v = data_q;
    endtask

    task automatic sfall();
        sclk = 1'b1; repeat (4) @(negedge clk);
        sclk = 1'b0; repeat (4) @(negedge clk);
    endtask

    task automatic commit(input logic [7:0] a, input logic [7:0] d, input logic [7:0] c);
        wr(S_CTRL, 8'h04); wr(S_ADDR, a); wr(S_DATA, d);
        wr(S_KEY, 8'h55); wr(S_KEY, 8'hAA); wr(S_CTRL, c);
    endtask

    task automatic finish_write(output int n);
        repeat (3) sfall();
        sclk = 1'b1; repeat (4) @(negedge clk);
        sclk = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (busy && n < 200);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errs, checks + 1);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int n;
        void'($urandom(32'd4242));
        for (int i = 0; i < 256; i++) mdl[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(ctrl_q == 8'h00 && !busy && addr_q == 8'h00 && data_q == 8'h00, "R1", ctrl_q, 0);
        rd(8'h10, v);
        chk(v == 8'hFF, "R1/R2 erased read", v, 8'hFF);

        // R4 R6 R7 R8 directed good write
        commit(8'h10, 8'h5A, 8'h06);
        chk(busy && ctrl_q == 8'h06, "R4 accepted", ctrl_q, 8'h06);
        repeat (3) sfall();
        chk(busy, "R6 busy before 4th edge", busy, 1);
        sclk = 1'b1; repeat (4) @(negedge clk);
        sclk = 1'b0;
        n = 0;
        do begin @(negedge clk); n++; end while (busy && n < 200);
        chk(n == EXP_LAT, "R6 latency", n, EXP_LAT);
        chk(ctrl_q == exp_ctrl(0), "R8 completion", ctrl_q, exp_ctrl(0));
        rd(8'h10, v);
        chk(v == 8'h5A, "R7 stored", v, 8'h5A); mdl[8'h10] = 8'h5A;

        wr(S_CTRL, 8'h04);
        chk(ctrl_q == 8'h04, "R8 clear flags", ctrl_q, 8'h04);

        // R5 no unlock
        wr(S_ADDR, 8'h10); wr(S_DATA, 8'h11); wr(S_CTRL, 8'h06);
        chk(ctrl_q == 8'h0C && !busy, "R5 rejected", ctrl_q, 8'h0C);
        rd(8'h10, v);
        chk(v == 8'h5A, "R5 array unchanged", v, 8'h5A);

        // R3 reversed order
        wr(S_CTRL, 8'h04); wr(S_ADDR, 8'h10); wr(S_DATA, 8'h22);
        wr(S_KEY, 8'hAA); wr(S_KEY, 8'h55); wr(S_CTRL, 8'h06);
        chk(ctrl_q == 8'h0C && !busy, "R3 reversed", ctrl_q, 8'h0C);

        // R3 interleaved write
        wr(S_CTRL, 8'h04); wr(S_KEY, 8'h55); wr(S_DATA, 8'h22);
        wr(S_KEY, 8'hAA); wr(S_CTRL, 8'h06);
        chk(ctrl_q == 8'h0C && !busy, "R3 interleaved", ctrl_q, 8'h0C);

        // R3 control write without start cancels unlock
        wr(S_CTRL, 8'h04); wr(S_KEY, 8'h55); wr(S_KEY, 8'hAA);
        wr(S_CTRL, 8'h04); wr(S_CTRL, 8'h06);
        chk(ctrl_q == 8'h0C && !busy, "R3 cancel by control", ctrl_q, 8'h0C);

        // R4 write enable not set beforehand
        wr(S_CTRL, 8'h00); wr(S_KEY, 8'h55); wr(S_KEY, 8'hAA); wr(S_CTRL, 8'h06);
        chk(ctrl_q == 8'h0C && !busy, "R4 late wren", ctrl_q, 8'h0C);

        // R4 program select set
        wr(S_CTRL, 8'h04); wr(S_KEY, 8'h55); wr(S_KEY, 8'hAA); wr(S_CTRL, 8'h86);
        chk(ctrl_q == 8'h8C && !busy, "R4 psel", ctrl_q, 8'h8C);
        rd(8'h10, v);
        chk(v == 8'h5A, "R4 array unchanged", v, 8'h5A);

        // R9 traffic while busy
        commit(8'h20, 8'h33, 8'h06);
        wr(S_DATA, 8'h77);
        chk(data_q == 8'h33 && err_flag, "R9 write ignored", data_q, 8'h33);
        rd_stb = 1'b1; @(negedge clk); rd_stb = 1'b0;
        chk(data_q == 8'h33, "R9 read ignored", data_q, 8'h33);
        finish_write(n);
        rd(8'h20, v);
        chk(v == 8'h33, "R9 stored value", v, 8'h33); mdl[8'h20] = 8'h33;

        // R6 R8 R9 write on the completion edge
        commit(8'h21, 8'h44, 8'h06);
        repeat (3) sfall();
        sclk = 1'b1; repeat (4) @(negedge clk);
        sclk = 1'b0;
        repeat (EXP_LAT - 1) @(negedge clk);
        wr(S_DATA, 8'h99);
        chk(!busy, "R6 idle after completion edge", busy, 0);
        chk(ctrl_q == 8'h1C, "R8/R9 done and error", ctrl_q, 8'h1C);
        chk(data_q == 8'h44, "R9 same-edge write dropped", data_q, 8'h44);
        rd(8'h21, v);
        chk(v == 8'h44, "R7 overlap stored", v, 8'h44); mdl[8'h21] = 8'h44;

        // random mix
        for (int it = 0; it < 24; it++) begin
            int kind;
            logic [7:0] a, d;
            kind = int'($urandom % 4);
            a = 8'($urandom); d = 8'($urandom);
            wr(S_CTRL, 8'h04); wr(S_ADDR, a); wr(S_DATA, d);
            if (kind == 1) begin
                wr(S_CTRL, 8'h06);
            end else if (kind == 2) begin
                wr(S_KEY, 8'hAA); wr(S_KEY, 8'h55); wr(S_CTRL, 8'h06);
            end else begin
                wr(S_KEY, 8'h55); wr(S_KEY, 8'hAA);
                wr(S_CTRL, (kind == 3) ? 8'h46 : 8'h06);
            end
            if (kind == 0) begin
                finish_write(n);
                chk(n == EXP_LAT, "R6 random latency", n, EXP_LAT);
                mdl[a] = d;
            end
            chk(ctrl_q == exp_ctrl(kind), "R4/R5 random control", ctrl_q, exp_ctrl(kind));
            rd(a, v);
            chk(v == mdl[a], "R7 random readback", v, mdl[a]);
        end

        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule